// File: doc/BRIEF.md
# Direct-Mapped Address Translation Cache with Page-Table Refill

This block keeps a small set of recent virtual-to-physical page translations close to the requester. Every virtual page number is mapped to exactly one slot, taken from its low bits. The remaining upper bits are kept in the slot as a tag, so the slot names a single page. A request whose slot is valid and whose tag matches is answered on the next cycle with the stored frame number. The external page table is not touched on a hit.

When the lookup misses, the block stops accepting requests and sends one read to an external page-table port. It then waits, for as many cycles as needed, for the reply. A reply marked present is written into the slot, overwriting whatever the slot held, and the frame number is returned. A reply marked absent is reported to the requester as a page fault and nothing is stored.

Software-side events reach the block through two commands. A whole-table flush is used when the address space changes. A single-page invalidate is used when one page leaves memory; it only clears the slot if the stored tag names that same page.

Top module: `xlat_cache`

## Requirements
- R1: After reset every slot is invalid, `lk_ready` is 1, and `rs_valid` and `pt_req_valid` are 0.
- R2: The slot index is `vpn[IDX_W-1:0]` and the tag is the rest of the VPN; with `IDX_W` from 3 to 6 (8 to 64 slots). A refill overwrites its slot unconditionally, so two pages that share the low bits evict each other.
- R3: A lookup accepted while its slot is valid and its tag matches gives, one cycle later, `rs_valid`=1, `rs_ok`=1, `rs_fault`=0 and the stored frame on `rs_pfn`. No page-table read is issued.
- R4: A lookup that misses drives `pt_req_valid` high for exactly the one cycle after acceptance, with `pt_req_vpn` equal to the requested VPN. `lk_ready` stays 0 until the cycle after the page-table response.
- R5: A page-table response with `pt_rsp_present`=1 gives, one cycle later, `rs_ok`=1, `rs_fault`=0 and `rs_pfn`=`pt_rsp_pfn`. The entry is installed, so the next lookup of that page hits.
- R6: A response with `pt_rsp_present`=0 gives `rs_fault`=1 and `rs_ok`=0, and installs nothing. A hit never reports a fault.
- R7: A flush clears every slot, so lookups accepted after it miss. A lookup accepted in the same cycle as the flush still sees the old contents.
- R8: An invalidate clears the slot at the index of `inv_vpn` only if the stored tag equals that page's tag. A slot holding another page with the same index keeps its entry.
- R9: If a flush or invalidate occurs while a refill is outstanding, including the cycle of the response itself, the response is still returned to the requester but is not installed.
- R10: A page-table response that arrives while no refill is outstanding is ignored. No result is produced and nothing is installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_ready | output | 1 | Block can accept a lookup |
| rs_valid | output | 1 | Result present (one cycle) |
| rs_ok | output | 1 | Result is a translation |
| rs_fault | output | 1 | Result is a page fault |
| rs_pfn | output | PFN_W | Physical frame number |
| pt_req_valid | output | 1 | Page-table read request (one-cycle pulse) |
| pt_req_vpn | output | VPN_W | Page to read from the page table |
| pt_rsp_valid | input | 1 | Page-table response present |
| pt_rsp_present | input | 1 | Page is resident |
| pt_rsp_pfn | input | PFN_W | Frame number from the page table |
| flush | input | 1 | Invalidate all slots |
| inv_valid | input | 1 | Invalidate one page |
| inv_vpn | input | VPN_W | Page to invalidate |

## Verification
Two kinds of event can land in the same cycle, and each is tested for the order it must follow. A flush can coincide with the acceptance of a lookup; that lookup must still hit on the old contents, and the lookup that follows must miss. A flush or invalidate can also coincide with the page-table response; the translation must still be returned, but a later lookup of that page must miss. The bench drives these collisions on purpose and also mixes them at random. It judges every result against a reference copy of the slot contents that it updates in that same order.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } walk_st_e;

  typedef struct packed {
    logic ok;
    logic fault;
  } outcome_t;
endpackage

// File: rtl/xlat_slot_array.sv
module xlat_slot_array #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 17,
  parameter int PFN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic [PFN_W-1:0] rd_pfn,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PFN_W-1:0] wr_pfn,
  input  logic             flush,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic [TAG_W-1:0] inv_tag
);
  localparam int NSLOT = 1 << IDX_W;

  logic [NSLOT-1:0] vld_v;
  logic [TAG_W-1:0] tag_v [NSLOT];
  logic [PFN_W-1:0] pfn_v [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic             vld_r;
    logic             vld_d;
    logic             sel_wr;
    logic             sel_inv;
    logic [TAG_W-1:0] tag_r;
    logic [PFN_W-1:0] pfn_r;

    always_comb begin
      sel_wr  = wr_en && (wr_idx == IDX_W'(g));
      sel_inv = inv_en && (inv_idx == IDX_W'(g)) && (tag_r == inv_tag);
      vld_d   = vld_r;
      if (sel_wr)  vld_d = 1'b1;
      if (sel_inv) vld_d = 1'b0;
      if (flush)   vld_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_r <= 1'b0;
      else        vld_r <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (sel_wr) begin
        tag_r <= wr_tag;
        pfn_r <= wr_pfn;
      end
    end

    assign vld_v[g] = vld_r;
    assign tag_v[g] = tag_r;
    assign pfn_v[g] = pfn_r;
  end

  assign rd_hit = vld_v[rd_idx] && (tag_v[rd_idx] == rd_tag);
  assign rd_pfn = pfn_v[rd_idx];

  // R9: the walker must never install while an invalidation is in flight
  p_fill_not_killed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!flush && !inv_en));

  // R7: a flush leaves no slot valid
  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_v == '0));

  // R8: invalidate with a different tag keeps the slot
  p_inval_keeps_other_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !flush && vld_v[inv_idx] && (tag_v[inv_idx] != inv_tag))
      |=> vld_v[$past(inv_idx)]);
endmodule

// File: rtl/xlat_walk.sv
module xlat_walk
  import xlat_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PFN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_ready,
  input  logic             hit,
  input  logic [PFN_W-1:0] hit_pfn,
  output logic             pt_req_valid,
  output logic [VPN_W-1:0] pt_req_vpn,
  input  logic             pt_rsp_valid,
  input  logic             pt_rsp_present,
  input  logic [PFN_W-1:0] pt_rsp_pfn,
  input  logic             kill_now,
  output logic             fill_en,
  output logic [VPN_W-1:0] fill_vpn,
  output logic [PFN_W-1:0] fill_pfn,
  output logic             rs_valid,
  output outcome_t         rs_out,
  output logic [PFN_W-1:0] rs_pfn
);
  walk_st_e         state_q, state_d;
  logic [VPN_W-1:0] vpn_q;
  logic             vpn_en;
  logic             killed_q, killed_d;
  logic             req_q, req_d;
  logic             rsv_q, rsv_d;
  outcome_t         out_q, out_d;
  logic [PFN_W-1:0] pfn_q, pfn_d;
  logic             accept, rsp_take;

  always_comb begin
    accept   = lk_valid && (state_q == ST_IDLE);
    rsp_take = pt_rsp_valid && (state_q == ST_WAIT);

    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept && !hit) state_d = ST_WAIT;
      ST_WAIT: if (rsp_take)       state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase

    vpn_en = accept;

    killed_d = killed_q;
    if (accept)                                killed_d = 1'b0;
    else if ((state_q == ST_WAIT) && kill_now) killed_d = 1'b1;

    req_d = accept && !hit;

    rsv_d     = (accept && hit) || rsp_take;
    out_d     = '0;
    pfn_d     = pt_rsp_pfn;
    if (accept && hit) begin
      out_d.ok = 1'b1;
      pfn_d    = hit_pfn;
    end else if (rsp_take) begin
      out_d.ok    = pt_rsp_present;
      out_d.fault = !pt_rsp_present;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      killed_q <= 1'b0;
      req_q    <= 1'b0;
      rsv_q    <= 1'b0;
      out_q    <= '0;
    end else begin
      state_q  <= state_d;
      killed_q <= killed_d;
      req_q    <= req_d;
      rsv_q    <= rsv_d;
      out_q    <= out_d;
    end
  end

  always_ff @(posedge clk) begin
    if (vpn_en) vpn_q <= lk_vpn;
    if (rsv_d)  pfn_q <= pfn_d;
  end

  assign lk_ready     = (state_q == ST_IDLE);
  assign pt_req_valid = req_q;
  assign pt_req_vpn   = vpn_q;
  assign fill_en      = rsp_take && pt_rsp_present && !killed_q && !kill_now;
  assign fill_vpn     = vpn_q;
  assign fill_pfn     = pt_rsp_pfn;
  assign rs_valid     = rsv_q;
  assign rs_out       = out_q;
  assign rs_pfn       = pfn_q;

  // R4: the page-table request is a single-cycle pulse
  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pt_req_valid |=> !pt_req_valid);

  // R4: no new lookup is taken while a request is out
  p_busy_on_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pt_req_valid |-> !lk_ready);

  // R6: every result is exactly one of translation or fault
  p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> ($countones({rs_out.ok, rs_out.fault}) == 1));

  // R10: idle with no request gives no result next cycle
  p_stray_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_ready && !lk_valid) |=> !rs_valid);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PFN_W = 16,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_ready,
  output logic             rs_valid,
  output logic             rs_ok,
  output logic             rs_fault,
  output logic [PFN_W-1:0] rs_pfn,
  output logic             pt_req_valid,
  output logic [VPN_W-1:0] pt_req_vpn,
  input  logic             pt_rsp_valid,
  input  logic             pt_rsp_present,
  input  logic [PFN_W-1:0] pt_rsp_pfn,
  input  logic             flush,
  input  logic             inv_valid,
  input  logic [VPN_W-1:0] inv_vpn
);
  localparam int TAG_W = VPN_W - IDX_W;

  logic             rd_hit;
  logic [PFN_W-1:0] rd_pfn;
  logic             fill_en;
  logic [VPN_W-1:0] fill_vpn;
  logic [PFN_W-1:0] fill_pfn;
  logic             kill_now;
  outcome_t         rs_out;

  assign kill_now = flush || inv_valid;

  xlat_slot_array #(
    .IDX_W(IDX_W),
    .TAG_W(TAG_W),
    .PFN_W(PFN_W)
  ) u_slots (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (lk_vpn[IDX_W-1:0]),
    .rd_tag  (lk_vpn[VPN_W-1:IDX_W]),
    .rd_hit  (rd_hit),
    .rd_pfn  (rd_pfn),
    .wr_en   (fill_en),
    .wr_idx  (fill_vpn[IDX_W-1:0]),
    .wr_tag  (fill_vpn[VPN_W-1:IDX_W]),
    .wr_pfn  (fill_pfn),
    .flush   (flush),
    .inv_en  (inv_valid),
    .inv_idx (inv_vpn[IDX_W-1:0]),
    .inv_tag (inv_vpn[VPN_W-1:IDX_W])
  );

  xlat_walk #(
    .VPN_W(VPN_W),
    .PFN_W(PFN_W)
  ) u_walk (
    .clk            (clk),
    .rst_n          (rst_n),
    .lk_valid       (lk_valid),
    .lk_vpn         (lk_vpn),
    .lk_ready       (lk_ready),
    .hit            (rd_hit),
    .hit_pfn        (rd_pfn),
    .pt_req_valid   (pt_req_valid),
    .pt_req_vpn     (pt_req_vpn),
    .pt_rsp_valid   (pt_rsp_valid),
    .pt_rsp_present (pt_rsp_present),
    .pt_rsp_pfn     (pt_rsp_pfn),
    .kill_now       (kill_now),
    .fill_en        (fill_en),
    .fill_vpn       (fill_vpn),
    .fill_pfn       (fill_pfn),
    .rs_valid       (rs_valid),
    .rs_out         (rs_out),
    .rs_pfn         (rs_pfn)
  );

  assign rs_ok    = rs_out.ok;
  assign rs_fault = rs_out.fault;

  // R3: an accepted hit answers next cycle with the stored frame
  p_hit_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && rd_hit)
      |=> (rs_valid && rs_ok && !rs_fault && !pt_req_valid && (rs_pfn == $past(rd_pfn))));

  // R7: nothing can hit in the cycle after a flush
  p_flush_then_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rd_hit);

  // R5: an installed refill returns a translation
  p_fill_returns_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (rs_valid && rs_ok && (rs_pfn == $past(pt_rsp_pfn))));
endmodule

// File: tb/xlat_cache_bench.sv
`timescale 1ns/1ps
module xlat_cache_bench;
  localparam int VPN_W = 20;
  localparam int PFN_W = 16;
  localparam int IDX_W = 3;
  localparam int NSLOT = 1 << IDX_W;
  localparam int TAG_W = VPN_W - IDX_W;

  logic             clk;
  logic             rst_n;
  logic             lk_valid;
  logic [VPN_W-1:0] lk_vpn;
  logic             lk_ready;
  logic             rs_valid, rs_ok, rs_fault;
  logic [PFN_W-1:0] rs_pfn;
  logic             pt_req_valid;
  logic [VPN_W-1:0] pt_req_vpn;
  logic             pt_rsp_valid, pt_rsp_present;
  logic [PFN_W-1:0] pt_rsp_pfn;
  logic             flush, inv_valid;
  logic [VPN_W-1:0] inv_vpn;

  int  total = 0;
  int  bad   = 0;
  bit  finished = 0;

  bit               m_vld [NSLOT];
  logic [TAG_W-1:0] m_tag [NSLOT];
  logic [PFN_W-1:0] m_pfn [NSLOT];

  xlat_cache #(.VPN_W(VPN_W), .PFN_W(PFN_W), .IDX_W(IDX_W)) u_xlat_cache (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_ready(lk_ready),
    .rs_valid(rs_valid), .rs_ok(rs_ok), .rs_fault(rs_fault), .rs_pfn(rs_pfn),
    .pt_req_valid(pt_req_valid), .pt_req_vpn(pt_req_vpn),
    .pt_rsp_valid(pt_rsp_valid), .pt_rsp_present(pt_rsp_present), .pt_rsp_pfn(pt_rsp_pfn),
    .flush(flush), .inv_valid(inv_valid), .inv_vpn(inv_vpn)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit pt_present(input logic [VPN_W-1:0] v);
    return v[7:4] != 4'hF;
  endfunction

  function automatic logic [PFN_W-1:0] pt_pfn(input logic [VPN_W-1:0] v);
    return PFN_W'(v * 37 + 11);
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NSLOT; i++) m_vld[i] = 1'b0;
  endtask

  task automatic model_inv(input logic [VPN_W-1:0] v);
    if (m_vld[v[IDX_W-1:0]] && m_tag[v[IDX_W-1:0]] == v[VPN_W-1:IDX_W])
      m_vld[v[IDX_W-1:0]] = 1'b0;
  endtask

  // kill: 0 none, 1 flush with response, 2 invalidate with response
  task automatic lookup(input logic [VPN_W-1:0] v, input int dly, input int kill,
                        input logic [VPN_W-1:0] iv, input bit flush_acc, output bit was_hit);
    logic [IDX_W-1:0] ix;
    bit               exp_hit;
    logic [PFN_W-1:0] exp_pfn;
    bit               pres;
    ix      = v[IDX_W-1:0];
    exp_hit = m_vld[ix] && (m_tag[ix] == v[VPN_W-1:IDX_W]);
    exp_pfn = m_pfn[ix];
    was_hit = exp_hit;
    @(negedge clk);
    chk(lk_ready == 1'b1, "R4 ready before lookup", 32'(lk_ready), 1);
    lk_valid = 1'b1; lk_vpn = v; flush = flush_acc;
    @(negedge clk);
    lk_valid = 1'b0; flush = 1'b0;
    if (flush_acc) model_clear();
    if (exp_hit) begin
      chk(rs_valid && rs_ok && !rs_fault, "R3 hit flags", {29'd0, rs_valid, rs_ok, rs_fault}, 32'h6);
      chk(rs_pfn == exp_pfn, "R3 hit frame", 32'(rs_pfn), 32'(exp_pfn));
      chk(!pt_req_valid, "R3 no table read on hit", 32'(pt_req_valid), 0);
    end else begin
      chk(pt_req_valid && pt_req_vpn == v, "R4 table request", 32'(pt_req_vpn), 32'(v));
      chk(!lk_ready && !rs_valid, "R4 busy on miss", {30'd0, lk_ready, rs_valid}, 0);
      for (int d = 0; d < dly; d++) begin
        @(negedge clk);
        chk(!lk_ready && !pt_req_valid, "R4 waiting", {30'd0, lk_ready, pt_req_valid}, 0);
      end
      pres = pt_present(v);
      pt_rsp_valid = 1'b1; pt_rsp_present = pres; pt_rsp_pfn = pt_pfn(v);
      if (kill == 1) flush = 1'b1;
      if (kill == 2) begin inv_valid = 1'b1; inv_vpn = iv; end
      @(negedge clk);
      pt_rsp_valid = 1'b0; flush = 1'b0; inv_valid = 1'b0;
      if (pres) begin
        chk(rs_valid && rs_ok && !rs_fault, "R5 fill flags", {29'd0, rs_valid, rs_ok, rs_fault}, 32'h6);
        chk(rs_pfn == pt_pfn(v), "R5 fill frame", 32'(rs_pfn), 32'(pt_pfn(v)));
      end else begin
        chk(rs_valid && !rs_ok && rs_fault, "R6 fault flags", {29'd0, rs_valid, rs_ok, rs_fault}, 32'h5);
      end
      chk(lk_ready, "R4 ready after response", 32'(lk_ready), 1);
      if (kill == 1) model_clear();
      else if (kill == 2) model_inv(iv);
      else if (pres) begin
        m_vld[ix] = 1'b1; m_tag[ix] = v[VPN_W-1:IDX_W]; m_pfn[ix] = pt_pfn(v);
      end
    end
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    model_clear();
  endtask

  task automatic do_inv(input logic [VPN_W-1:0] v);
    @(negedge clk); inv_valid = 1'b1; inv_vpn = v;
    @(negedge clk); inv_valid = 1'b0;
    model_inv(v);
  endtask

  task automatic stray(input logic [VPN_W-1:0] v);
    @(negedge clk);
    pt_rsp_valid = 1'b1; pt_rsp_present = 1'b1; pt_rsp_pfn = pt_pfn(v);
    @(negedge clk);
    pt_rsp_valid = 1'b0;
    chk(!rs_valid && lk_ready, "R10 stray response ignored", {30'd0, rs_valid, lk_ready}, 1);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R4 watchdog expired actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    bit h;
    logic [VPN_W-1:0] va, vc, vf, vk;
    void'($urandom(32'd2024));
    rst_n = 1'b0; lk_valid = 1'b0; lk_vpn = '0; pt_rsp_valid = 1'b0;
    pt_rsp_present = 1'b0; pt_rsp_pfn = '0; flush = 1'b0; inv_valid = 1'b0; inv_vpn = '0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lk_ready && !rs_valid && !pt_req_valid, "R1 reset state",
        {29'd0, lk_ready, rs_valid, pt_req_valid}, 32'h4);
    for (int i = 0; i < NSLOT; i++) begin
      lookup(VPN_W'(i), 0, 0, '0, 1'b0, h);
      chk(!h, "R1 all slots empty", 32'(h), 0);
    end

    va = 20'h00012; vc = 20'h0001A; vf = 20'h000F3; vk = 20'h00025;
    lookup(va, 1, 0, '0, 1'b0, h);
    lookup(va, 0, 0, '0, 1'b0, h);
    chk(h, "R3 second lookup hits", 32'(h), 1);
    lookup(vc, 2, 0, '0, 1'b0, h);
    lookup(va, 0, 0, '0, 1'b0, h);
    chk(!h, "R2 same index evicts", 32'(h), 0);
    lookup(vf, 3, 0, '0, 1'b0, h);
    lookup(vf, 0, 0, '0, 1'b0, h);
    chk(!h, "R6 fault not installed", 32'(h), 0);

    do_inv(vc);
    lookup(va, 0, 0, '0, 1'b0, h);
    do_inv(20'h1000A);
    lookup(va, 0, 0, '0, 1'b0, h);
    chk(h, "R8 other tag kept", 32'(h), 1);
    do_inv(va);
    lookup(va, 0, 0, '0, 1'b0, h);
    chk(!h, "R8 matching tag cleared", 32'(h), 0);

    lookup(va, 0, 0, '0, 1'b1, h);
    chk(h, "R7 flush cycle sees old entry", 32'(h), 1);
    lookup(va, 0, 0, '0, 1'b0, h);
    chk(!h, "R7 miss after flush", 32'(h), 0);

    lookup(vk, 2, 1, '0, 1'b0, h);
    lookup(vk, 0, 0, '0, 1'b0, h);
    chk(!h, "R9 flush blocks install", 32'(h), 0);
    lookup(20'h0002D, 0, 2, 20'h00077, 1'b0, h);
    lookup(20'h0002D, 0, 0, '0, 1'b0, h);
    chk(!h, "R9 invalidate blocks install", 32'(h), 0);

    stray(20'h00031);
    lookup(20'h00031, 0, 0, '0, 1'b0, h);
    chk(!h, "R10 stray not installed", 32'(h), 0);

    for (int n = 0; n < 600; n++) begin
      logic [VPN_W-1:0] v;
      int op;
      v = VPN_W'((($urandom % 6) << IDX_W) | ($urandom % NSLOT));
      if ($urandom % 8 == 0) v = v | 20'h000F0;
      op = $urandom % 100;
      if (op < 68)      lookup(v, $urandom % 4, 0, '0, 1'b0, h);
      else if (op < 73) do_flush();
      else if (op < 85) do_inv(v);
      else if (op < 90) lookup(v, $urandom % 3, 1 + ($urandom % 2), VPN_W'($urandom % 48), 1'b0, h);
      else if (op < 95) lookup(v, 0, 0, '0, 1'b1, h);
      else              stray(v);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule